// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block drives the processor's active-low reset from two sources: a digital flag that says the supply is below its threshold, and a watchdog that expects the software to keep changing a single input line. While the supply flag is raised, reset stays active. Once the flag drops, reset is released only after a fixed number of timebase ticks. If the watchdog line stops changing for a set number of ticks, the block produces one reset pulse of that same length and drives a watchdog-out flag low.

The watchdog line has three levels. They arrive as a data bit and a qualifier bit that marks the line as floating or at mid-level. While the qualifier is set, the watchdog is disabled. The reset length and the watchdog timeout are both counted in ticks of one shared timebase. That timebase either divides the system clock by one of two parameterised ratios (short or long period) or counts single-cycle ticks supplied from outside. Analog comparators and oscillators are not part of the block: the supply comparison arrives as a synchronous flag, and timing is derived from the clock.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rst_n_o` is 0 and `wdo_n_o` is 1 after that edge.
- R2: A cycle with `supply_low_i` = 1 makes `rst_n_o` 0 from the next clock edge on, for as long as the flag stays high.
- R3: After `supply_low_i` falls, or after `rst_n` is released, `rst_n_o` stays 0 until RST_TICKS timebase ticks have elapsed. A new supply-low cycle restarts that count from zero.
- R4: With `tb_int_i` = 1, the timebase gives one tick every SHORT_DIV clock cycles when `tb_long_i` = 0, and every LONG_DIV clock cycles when `tb_long_i` = 1.
- R5: With `tb_int_i` = 0, every cycle in which `ext_tick_i` = 1 counts as exactly one tick, applied one cycle later. No other ticks occur in this mode.
- R6: `wdi_i` passes through two synchronising flops. Every change of the synchronised level clears the watchdog timer.
- R7: When the watchdog is enabled, reset is inactive, and the synchronised `wdi_i` stays unchanged for WDT_TICKS ticks, `rst_n_o` and `wdo_n_o` both go to 0 on the same edge. The resulting reset pulse lasts RST_TICKS ticks.
- R8: While the synchronised `wdi_mid_i` = 1 (floating or mid-level), the watchdog never fires and its timer is held at zero.
- R9: Once `wdo_n_o` is 0, it stays 0 until the next change of the synchronised `wdi_i` or a cycle with `supply_low_i` = 1, whichever comes first. It stays 0 past the end of its own reset pulse.
- R10: While reset is active, the watchdog timer is held at zero, so a timeout counts only ticks that fall after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_low_i | input | 1 | Supply-below-threshold flag, synchronous to clk |
| wdi_i | input | 1 | Watchdog toggle line (asynchronous) |
| wdi_mid_i | input | 1 | 1 when the watchdog line is floating or mid-level (asynchronous) |
| tb_int_i | input | 1 | 1 selects the internal divider, 0 selects external ticks |
| tb_long_i | input | 1 | Internal period select: 0 short, 1 long |
| ext_tick_i | input | 1 | External timebase tick, one cycle wide |
| rst_n_o | output | 1 | Active-low processor reset |
| wdo_n_o | output | 1 | Active-low watchdog-timeout flag |

## Verification
The watchdog is exercised with four kinds of input. Toggling faster than the timeout shows that edges really clear the timer. A line held still shows the fire, the reset pulse and the repeated pulses that follow. A line held still with the mid qualifier set must produce no reset at all. A single toggle after a timeout shows that the flag clears on an edge and not when the pulse ends. The reset path is driven by one supply-low interval, and by a second interval that starts while the release count is running, which shows whether the count restarts. The timebase is run with the short divider, the long divider and sparse external ticks, with a toggle spacing chosen to fail under the short period and pass under the long one, so the two periods produce different results.

// File: rtl/sup_pkg.sv
// Package sup_pkg
// Shared helpers for the supervisory reset block.
// Assumes: every count is a positive integer.
package sup_pkg;

    // Width needed to hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
// Module sup_sync2
// A two-flop synchroniser for W independent asynchronous bits.
// Assumes: each bit is a level signal. No multi-bit coherence is guaranteed.
module sup_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Pass each bit through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/sup_timebase.sv
// Module sup_timebase
// Shared tick source. In internal mode it divides clk by SHORT_DIV or
// LONG_DIV. In external mode it registers a one-cycle tick from outside.
// Assumes: ext_tick_i is synchronous and at most one cycle wide per tick.
module sup_timebase
    import sup_pkg::*;
#(
    parameter int SHORT_DIV = 100,
    parameter int LONG_DIV  = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_int_i,
    input  logic long_sel_i,
    input  logic ext_tick_i,
    output logic tick_o
);
    localparam int PW = cnt_width(max2(SHORT_DIV, LONG_DIV));
    localparam logic [PW-1:0] SHORT_LIM = PW'(SHORT_DIV - 1);
    localparam logic [PW-1:0] LONG_LIM  = PW'(LONG_DIV - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    // Pick the terminal count for the selected internal period.
    always_comb begin
        lim = long_sel_i ? LONG_LIM : SHORT_LIM;
    end

    // Advance the prescaler, or forward the external tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_o <= 1'b0;
        end else if (use_int_i) begin
            if (pre_q >= lim) begin
                pre_q  <= '0;
                tick_o <= 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
                tick_o <= 1'b0;
            end
        end else begin
            pre_q  <= '0;
            tick_o <= ext_tick_i;
        end
    end
endmodule

// File: rtl/sup_watchdog.sv
// Module sup_watchdog
// Counts timebase ticks since the last change of the synchronised watchdog
// line. Raises a one-cycle fire at the timeout and holds the watchdog-out
// flag until a new edge or a supply-low cycle.
// Assumes: wdi_s_i and mid_s_i are already synchronised to clk.
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int WDT_TICKS = 4,
    parameter int CW        = cnt_width(WDT_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wdi_s_i,
    input  logic          mid_s_i,
    input  logic          tick_i,
    input  logic          rst_active_i,
    input  logic          supply_low_i,
    output logic          fire_o,
    output logic          edge_o,
    output logic          en_o,
    output logic          wdo_low_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] LAST = CW'(WDT_TICKS - 1);

    logic prev_q;

    // Detect an edge and decide whether this tick ends the timeout.
    always_comb begin
        edge_o = wdi_s_i ^ prev_q;
        en_o   = ~mid_s_i;
        fire_o = en_o & ~rst_active_i & ~edge_o & tick_i & (count_o == LAST);
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= wdi_s_i;
    end

    // Timeout counter: cleared by an edge, when disabled, or during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (edge_o || !en_o || rst_active_i) begin
            count_o <= '0;
        end else if (tick_i) begin
            count_o <= (count_o == LAST) ? '0 : count_o + 1'b1;
        end
    end

    // Watchdog-out flag: set on fire, cleared by an edge or a supply-low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdo_low_o <= 1'b0;
        end else if (supply_low_i || edge_o) begin
            wdo_low_o <= 1'b0;
        end else if (fire_o) begin
            wdo_low_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sup_reset_ctrl.sv
// Module sup_reset_ctrl
// Holds reset while the supply is low and for RST_TICKS ticks afterwards.
// A watchdog fire starts the same timed pulse.
// Assumes: fire_i is a one-cycle pulse and tick_i comes from the shared timebase.
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int RST_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic fire_i,
    input  logic tick_i,
    output logic rst_active_o
);
    localparam int RW = cnt_width(RST_TICKS);
    localparam logic [RW-1:0] LAST = RW'(RST_TICKS - 1);

    logic [RW-1:0] cnt_q;

    // Start, restart or count down the reset hold interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_active_o <= 1'b1;
            cnt_q        <= '0;
        end else if (supply_low_i || fire_i) begin
            rst_active_o <= 1'b1;
            cnt_q        <= '0;
        end else if (rst_active_o && tick_i) begin
            if (cnt_q == LAST) begin
                rst_active_o <= 1'b0;
                cnt_q        <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_reset_wdog.sv
// Module sup_reset_wdog (top)
// Supervisory reset generator: supply-low reset with a timed release,
// a watchdog on a three-level input, and one shared timebase.
// Assumes: supply_low_i is synchronous to clk. wdi_i and wdi_mid_i are asynchronous.
module sup_reset_wdog
    import sup_pkg::*;
#(
    parameter int SHORT_DIV = 100,
    parameter int LONG_DIV  = 1600,
    parameter int RST_TICKS = 2,
    parameter int WDT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic wdi_i,
    input  logic wdi_mid_i,
    input  logic tb_int_i,
    input  logic tb_long_i,
    input  logic ext_tick_i,
    output logic rst_n_o,
    output logic wdo_n_o
);
    localparam int WD_CW = cnt_width(WDT_TICKS);

    logic [1:0]       sync_q;
    logic             tick;
    logic             fire;
    logic             wdi_edge;
    logic             wd_en;
    logic             wdo_low;
    logic             rst_active;
    logic [WD_CW-1:0] wd_count;

    sup_sync2 #(.W(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wdi_mid_i, wdi_i}),
        .q_o   (sync_q)
    );

    sup_timebase #(.SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV)) i_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_int_i  (tb_int_i),
        .long_sel_i (tb_long_i),
        .ext_tick_i (ext_tick_i),
        .tick_o     (tick)
    );

    sup_watchdog #(.WDT_TICKS(WDT_TICKS), .CW(WD_CW)) i_wd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdi_s_i      (sync_q[0]),
        .mid_s_i      (sync_q[1]),
        .tick_i       (tick),
        .rst_active_i (rst_active),
        .supply_low_i (supply_low_i),
        .fire_o       (fire),
        .edge_o       (wdi_edge),
        .en_o         (wd_en),
        .wdo_low_o    (wdo_low),
        .count_o      (wd_count)
    );

    sup_reset_ctrl #(.RST_TICKS(RST_TICKS)) i_rc (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low_i),
        .fire_i       (fire),
        .tick_i       (tick),
        .rst_active_o (rst_active)
    );

    // Drive the active-low outputs from the registered state.
    always_comb begin
        rst_n_o = ~rst_active;
        wdo_n_o = ~wdo_low;
    end
endmodule

// File: rtl/sup_reset_wdog_chk.sv
// Module sup_reset_wdog_chk
// Temporal checks on the supervisory block, attached with bind.
// Assumes: connected to the top-level ports and a few internal nets.
module sup_reset_wdog_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_low_i,
    input logic          rst_n_o,
    input logic          wdo_n_o,
    input logic          tick,
    input logic          wdi_edge,
    input logic          wd_en,
    input logic          rst_active,
    input logic [CW-1:0] wd_count
);
    // R2: a supply-low cycle forces reset on the next edge.
    a_r2_supply_resets: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> !rst_n_o);

    // R3: reset is released only on a timebase tick.
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> $past(tick));

    // R6: an edge on the watchdog line clears the timer.
    a_r6_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wdi_edge |=> (wd_count == '0));

    // R7: the watchdog flag falls together with a fresh reset.
    a_r7_fire_resets: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n_o) |-> $fell(rst_n_o));

    // R8: a disabled watchdog leaves the flag alone without edge or supply event.
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && !wdi_edge && !supply_low_i) |=> $stable(wdo_n_o));

    // R9: the flag holds low without an edge or supply-low cycle.
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdo_n_o && !wdi_edge && !supply_low_i) |=> !wdo_n_o);

    // R9: a supply-low cycle clears the flag.
    a_r9_supply_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> wdo_n_o);

    // R10: the timer is held at zero while reset is active.
    a_r10_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> (wd_count == '0));
endmodule

bind sup_reset_wdog sup_reset_wdog_chk #(.CW(WD_CW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low_i),
    .rst_n_o      (rst_n_o),
    .wdo_n_o      (wdo_n_o),
    .tick         (tick),
    .wdi_edge     (wdi_edge),
    .wd_en        (wd_en),
    .rst_active   (rst_active),
    .wd_count     (wd_count)
);

// File: tb/test_sup_reset_wdog.sv
// Bench for sup_reset_wdog: a behavioural model advanced on each rising
// edge and compared with the outputs on each falling edge, plus directed checks.
module test_sup_reset_wdog;
    localparam int SD = 4;
    localparam int LD = 12;
    localparam int RT = 3;
    localparam int WT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0, wdi = 1'b0, wdi_mid = 1'b0;
    logic tb_int = 1'b1, tb_long = 1'b0, ext_tick = 1'b0;
    logic rst_n_o, wdo_n_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    // Model state, kept as plain integers.
    int m_s1, m_s2, m_s3, m_m1, m_m2, m_pc, m_tk, m_ra, m_rc, m_wc, m_wl;
    int v_edge, v_fire, v_old_ra;

    always #2 clk = ~clk;

    sup_reset_wdog #(.SHORT_DIV(SD), .LONG_DIV(LD), .RST_TICKS(RT), .WDT_TICKS(WT)) i_sup_reset_wdog (
        .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .wdi_i(wdi),
        .wdi_mid_i(wdi_mid), .tb_int_i(tb_int), .tb_long_i(tb_long),
        .ext_tick_i(ext_tick), .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o)
    );

    // Advance the reference model from the inputs seen at the edge.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_m1 = 0; m_m2 = 0;
            m_pc = 0; m_tk = 0; m_ra = 1; m_rc = 0; m_wc = 0; m_wl = 0;
        end else begin
            v_edge   = (m_s2 != m_s3) ? 1 : 0;
            v_old_ra = m_ra;
            v_fire   = (m_m2 == 0 && m_ra == 0 && v_edge == 0 && m_tk == 1 && m_wc == WT - 1) ? 1 : 0;
            if (supply_low || v_fire == 1) begin
                m_ra = 1; m_rc = 0;
            end else if (m_ra == 1 && m_tk == 1) begin
                if (m_rc == RT - 1) begin m_ra = 0; m_rc = 0; end
                else m_rc = m_rc + 1;
            end
            if (v_edge == 1 || m_m2 == 1 || v_old_ra == 1) m_wc = 0;
            else if (m_tk == 1) m_wc = (m_wc == WT - 1) ? 0 : m_wc + 1;
            if (supply_low || v_edge == 1) m_wl = 0;
            else if (v_fire == 1) m_wl = 1;
            if (tb_int) begin
                if (m_pc >= (tb_long ? LD : SD) - 1) begin m_pc = 0; m_tk = 1; end
                else begin m_pc = m_pc + 1; m_tk = 0; end
            end else begin
                m_pc = 0; m_tk = ext_tick ? 1 : 0;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = wdi ? 1 : 0;
            m_m2 = m_m1; m_m1 = wdi_mid ? 1 : 0;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare both outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(cur_req, rst_n_o, (m_ra == 0), "rst_n_o vs model");
            check(cur_req, wdo_n_o, (m_wl == 0), "wdo_n_o vs model");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_for(input int cycles, input int spacing);
        for (int i = 0; i < cycles / spacing; i++) begin
            cyc(spacing);
            wdi = ~wdi;
        end
    endtask

    initial begin
        // R1: reset state
        cyc(4);
        check("R1", rst_n_o, 1'b0, "reset held");
        check("R1", wdo_n_o, 1'b1, "flag idle in reset");

        // R3: timed release after block reset, watchdog parked at mid-level
        cur_req = "R3";
        wdi_mid = 1'b1;
        rst_n = 1'b1;
        cyc(6);
        check("R3", rst_n_o, 1'b0, "still held before delay");
        cyc(30);
        check("R3", rst_n_o, 1'b1, "released after delay");

        // R2: supply-low forces reset, a second event restarts the count
        cur_req = "R2";
        supply_low = 1'b1; cyc(5);
        check("R2", rst_n_o, 1'b0, "reset during supply low");
        supply_low = 1'b0; cyc(6);
        supply_low = 1'b1; cyc(1);
        supply_low = 1'b0; cyc(8);
        check("R3", rst_n_o, 1'b0, "restarted count still running");
        cyc(30);

        // R6: toggling faster than the timeout keeps everything quiet
        cur_req = "R6";
        wdi_mid = 1'b0;
        toggle_for(120, 6);
        check("R6", rst_n_o, 1'b1, "no reset while toggling");
        check("R6", wdo_n_o, 1'b1, "no flag while toggling");

        // R7: stop toggling, watchdog fires, pulses repeat
        cur_req = "R7";
        cyc(60);
        check("R7", wdo_n_o, 1'b0, "flag low after timeout");

        // R9: one edge clears the flag, a supply-low cycle also clears it
        cur_req = "R9";
        wdi = ~wdi; cyc(4);
        check("R9", wdo_n_o, 1'b1, "flag cleared by edge");
        cyc(40);
        check("R9", wdo_n_o, 1'b0, "flag set again");
        supply_low = 1'b1; cyc(2);
        supply_low = 1'b0;
        check("R9", wdo_n_o, 1'b1, "flag cleared by supply low");

        // R8: mid-level input disables the watchdog
        cur_req = "R8";
        wdi_mid = 1'b1;
        cyc(120);
        check("R8", rst_n_o, 1'b1, "no reset while disabled");
        check("R8", wdo_n_o, 1'b1, "no flag while disabled");

        // R4: long period tolerates slower toggling, then times out
        cur_req = "R4";
        wdi_mid = 1'b0; tb_long = 1'b1;
        toggle_for(180, 30);
        check("R4", rst_n_o, 1'b1, "long period no reset");
        cyc(100);
        check("R4", wdo_n_o, 1'b0, "long period timeout");
        tb_long = 1'b0;
        toggle_for(60, 30);

        // R5: external ticks only
        cur_req = "R5";
        tb_int = 1'b0;
        cyc(40);
        for (int i = 0; i < 30; i++) begin
            ext_tick = 1'b1; cyc(1);
            ext_tick = 1'b0; cyc(2);
        end
        check("R5", wdo_n_o, 1'b0, "external ticks time out");
        tb_int = 1'b1;

        // R10: timer held during a long supply-low interval
        cur_req = "R10";
        wdi = ~wdi;
        supply_low = 1'b1; cyc(50);
        supply_low = 1'b0; cyc(14);
        check("R10", wdo_n_o, 1'b1, "no early timeout after reset");
        cyc(30);
        check("R10", wdo_n_o, 1'b0, "timeout after full window");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Bench watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule